// File: doc/BRIEF.md
# Registered Sixteen-Function Nybble ALU Bank

This block is a 4-bit arithmetic and logic unit built from sixteen function units that work side by side. All units share one A operand register and one B operand register. Each unit performs one fixed operation and keeps its own registered data nybble and its own registered status nybble. Writing either operand causes every unit to recompute and capture a fresh result and fresh flags on the following clock edge. A program can therefore load A and B once and then read the outcome of any of the sixteen operations.

A separate write port loads a carry bit into the status register of one addressed unit. Units that take a carry or borrow input use their own stored carry bit, so a carry can be seeded before an operand write. One read port returns the data nybble and status nybble of the unit selected by a 4-bit function address. Reading has no side effects.

Top module: `nyb_alu_bank`

## Requirements
- R1: After a clock edge with `rst_n` low, the A and B registers and every unit's data and status nybbles are zero.
- R2: With `ab_wr_en` high at a clock edge, `ab_wr_data` is stored in A when `ab_sel` is 0 and in B when `ab_sel` is 1. Every unit then captures its new result and flags on the next edge, and not before.
- R3: Unit 0 (ADD) yields A+B and unit 1 (ADDC) yields A+B+Cin. Carry-out goes to C. O is set on two's-complement overflow.
- R4: Unit 2 (SUB) and unit 8 (CMP) yield A-B, and unit 3 (SUBB) yields A-B-Cin. C is 1 when a borrow occurs, and O is set on two's-complement overflow.
- R5: ADDC, SUBB, ROLC (unit 14) and RORC (unit 15) take as Cin the C bit held in that unit's own status register at the capture edge.
- R6: Unit 4 is AND, unit 5 is OR, unit 6 is XOR and unit 7 is NOT A. For these units C and O are cleared.
- R7: The shift and rotate units act on A only, and the bit shifted out goes to C. SHL (unit 9) and SHR (unit 10) fill with 0. SHRA (unit 11) keeps bit 3. ROL (12) and ROR (13) rotate within A. ROLC (14) and RORC (15) shift Cin into the vacated bit. O is cleared for all of them.
- R8: Status bits are C = bit 0, Z = bit 1, N = bit 2, O = bit 3. Z is set when the result nybble is zero, and N equals result bit 3.
- R9: When `cy_wr_en` is high at an edge, bit 0 of `cy_wr_data` is written into the C bit of the unit at `cy_wr_addr`. No other unit and no other bit changes. If that unit also captures on the same edge, the loaded value wins for C.
- R10: Reading through `rd_addr` changes no stored value. Without an operand write or carry load, all units hold their data and status.
- R11: `rd_data` and `rd_stat` show, with no clock delay, the data and status nybbles of the unit numbered `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_wr_en | input | 1 | Operand write strobe |
| ab_sel | input | 1 | Operand select: 0 = A, 1 = B |
| ab_wr_data | input | 4 | Operand value |
| cy_wr_en | input | 1 | Carry-load strobe |
| cy_wr_addr | input | 4 | Unit whose C bit is loaded |
| cy_wr_data | input | 4 | Nybble whose bit 0 is loaded into C |
| rd_addr | input | 4 | Unit selected for reading |
| rd_data | output | 4 | Data nybble of the selected unit |
| rd_stat | output | 4 | Status nybble of the selected unit |

## Verification
The bench sweeps operand pairs chosen to hit signed overflow in both directions, borrow, and all-ones and all-zero results. A unit with a swapped overflow term or borrow polarity shows wrong O or C flags on those pairs. The carry-chained units are run after seeding their C bits, so a design that fed a shared or constant carry into ADDC, SUBB, ROLC or RORC would give a wrong result nybble.

Directed cases cover the following faults:
- A read taken one cycle after the operand strobe catches a design that captures a cycle early.
- A carry load on the same edge as a capture catches a design that lets the computed carry override the loaded one.
- Repeated reads across idle cycles catch any read side effect or any drift in the stored values.

// File: rtl/nyb_alu_pkg.sv
// Shared constants and types for the nybble ALU bank.
// Assumes the status layout holds four flags, whatever DATA_W is.
package nyb_alu_pkg;
    localparam int DATA_W  = 4;
    localparam int NUM_FN  = 16;
    localparam int ADDR_W  = $clog2(NUM_FN);
    localparam int STAT_W  = 4;

    // Flag positions inside the status nybble.
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_O = 3;

    // The function address of each unit; the value is the unit number.
    typedef enum logic [ADDR_W-1:0] {
        OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBB = 4'd3,
        OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_NOT  = 4'd7,
        OP_CMP  = 4'd8,  OP_SHL  = 4'd9,  OP_SHR  = 4'd10, OP_SHRA = 4'd11,
        OP_ROL  = 4'd12, OP_ROR  = 4'd13, OP_ROLC = 4'd14, OP_RORC = 4'd15
    } nyb_op_e;
endpackage

// File: rtl/nyb_operand_regs.sv
// Holds the shared A and B operands and issues the capture pulse.
// Assumes at most one operand is written per cycle; the pulse is
// raised for the cycle that follows each operand write.
module nyb_operand_regs
    import nyb_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q,
    output logic         capture
);
    // Operand storage, steered by the select bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) b_q <= wr_data;
            else        a_q <= wr_data;
        end
    end

    // Delay the strobe by one cycle so that units see the new operand.
    always_ff @(posedge clk) begin
        if (!rst_n) capture <= 1'b0;
        else        capture <= wr_en;
    end

    p_capture_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> capture);
    p_operands_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/nyb_fn_unit.sv
// One function unit: it evaluates the fixed operation OP on the shared
// operands and its own stored carry, and it captures the result and flags
// when capture is high. A carry load overrides the C bit on the same edge.
module nyb_fn_unit
    import nyb_alu_pkg::*;
#(
    parameter int      W  = DATA_W,
    parameter nyb_op_e OP = OP_ADD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic              cy_load,
    input  logic              cy_bit,
    output logic [W-1:0]      data_q,
    output logic [STAT_W-1:0] stat_q
);
    localparam int MSB = W - 1;

    logic         cin;
    logic [W:0]   wide;
    logic [W-1:0] res;
    logic         c_out;
    logic         ovf;

    assign cin = stat_q[FLG_C];

    // Evaluate this unit's fixed operation.
    always_comb begin
        wide  = '0;
        res   = '0;
        c_out = 1'b0;
        ovf   = 1'b0;
        case (OP)
            OP_ADD, OP_ADDC: begin
                wide  = {1'b0, a} + {1'b0, b} + ((OP == OP_ADDC) ? {{W{1'b0}}, cin} : '0);
                res   = wide[W-1:0];
                c_out = wide[W];
                ovf   = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_SUB, OP_SUBB, OP_CMP: begin
                wide  = {1'b0, a} - {1'b0, b} - ((OP == OP_SUBB) ? {{W{1'b0}}, cin} : '0);
                res   = wide[W-1:0];
                c_out = wide[W];
                ovf   = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_SHL:  begin res = {a[MSB-1:0], 1'b0};   c_out = a[MSB]; end
            OP_SHR:  begin res = {1'b0, a[MSB:1]};     c_out = a[0];   end
            OP_SHRA: begin res = {a[MSB], a[MSB:1]};   c_out = a[0];   end
            OP_ROL:  begin res = {a[MSB-1:0], a[MSB]}; c_out = a[MSB]; end
            OP_ROR:  begin res = {a[0], a[MSB:1]};     c_out = a[0];   end
            OP_ROLC: begin res = {a[MSB-1:0], cin};    c_out = a[MSB]; end
            OP_RORC: begin res = {cin, a[MSB:1]};      c_out = a[0];   end
            default: res = '0;
        endcase
    end

    // Latch the result on capture; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= res;
    end

    // Latch the flags on capture; a carry load takes C on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            if (capture) begin
                stat_q[FLG_O] <= ovf;
                stat_q[FLG_N] <= res[MSB];
                stat_q[FLG_Z] <= ~|res;
                stat_q[FLG_C] <= c_out;
            end
            if (cy_load) stat_q[FLG_C] <= cy_bit;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !cy_load) |=> ($stable(data_q) && $stable(stat_q)));
    p_carry_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cy_load |=> (stat_q[FLG_C] == $past(cy_bit)));
    p_carry_load_only_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_load && !capture) |=> ($stable(data_q) && $stable(stat_q[STAT_W-1:1])));
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (stat_q[FLG_Z] == (data_q == '0)));
    p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (stat_q[FLG_N] == data_q[MSB]));

    if (OP inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL, OP_SHR, OP_SHRA,
                   OP_ROL, OP_ROR, OP_ROLC, OP_RORC}) begin : g_no_ovf
        p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            capture |=> !stat_q[FLG_O]);
    end
endmodule

// File: rtl/nyb_result_mux.sv
// Selects one unit's data and status nybbles by function address.
// Purely combinational; assumes NUM_FN equals 2**ADDR_W.
module nyb_result_mux
    import nyb_alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NUM_FN
) (
    input  logic [N-1:0][W-1:0]      data_all,
    input  logic [N-1:0][STAT_W-1:0] stat_all,
    input  logic [$clog2(N)-1:0]     sel,
    output logic [W-1:0]             data_o,
    output logic [STAT_W-1:0]        stat_o
);
    // Index the flattened unit outputs.
    always_comb begin
        data_o = data_all[sel];
        stat_o = stat_all[sel];
    end
endmodule

// File: rtl/nyb_alu_bank.sv
// Top of the sixteen-unit nybble ALU bank: the shared operand registers,
// one generated function unit per operation, carry-load decode and a read
// selector. Assumes the reset is synchronous and active low.
module nyb_alu_bank
    import nyb_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ab_wr_en,
    input  logic              ab_sel,
    input  logic [DATA_W-1:0] ab_wr_data,
    input  logic              cy_wr_en,
    input  logic [ADDR_W-1:0] cy_wr_addr,
    input  logic [DATA_W-1:0] cy_wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] rd_stat
);
    logic [DATA_W-1:0]             a_q;
    logic [DATA_W-1:0]             b_q;
    logic                          capture;
    logic [NUM_FN-1:0]             cy_load;
    logic [NUM_FN-1:0][DATA_W-1:0] data_all;
    logic [NUM_FN-1:0][STAT_W-1:0] stat_all;

    nyb_operand_regs #(.W(DATA_W)) u_opnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ab_wr_en),
        .wr_sel  (ab_sel),
        .wr_data (ab_wr_data),
        .a_q     (a_q),
        .b_q     (b_q),
        .capture (capture)
    );

    for (genvar i = 0; i < NUM_FN; i++) begin : g_unit
        // Decode the carry-load strobe for this unit.
        assign cy_load[i] = cy_wr_en && (cy_wr_addr == ADDR_W'(i));

        nyb_fn_unit #(.W(DATA_W), .OP(nyb_op_e'(i))) u_fn (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (capture),
            .a       (a_q),
            .b       (b_q),
            .cy_load (cy_load[i]),
            .cy_bit  (cy_wr_data[0]),
            .data_q  (data_all[i]),
            .stat_q  (stat_all[i])
        );
    end

    nyb_result_mux #(.W(DATA_W), .N(NUM_FN)) u_rd (
        .data_all (data_all),
        .stat_all (stat_all),
        .sel      (rd_addr),
        .data_o   (rd_data),
        .stat_o   (rd_stat)
    );

    p_one_carry_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cy_load));
endmodule

// File: tb/nyb_alu_bank_test.sv
`timescale 1ns/1ps
module nyb_alu_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ab_wr_en = 1'b0;
    logic       ab_sel = 1'b0;
    logic [3:0] ab_wr_data = '0;
    logic       cy_wr_en = 1'b0;
    logic [3:0] cy_wr_addr = '0;
    logic [3:0] cy_wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [3:0] rd_data;
    logic [3:0] rd_stat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] ma, mb;
    logic [3:0] mdata [16];
    logic [3:0] mstat [16];

    // Operand pairs {A,B}: overflow, borrow, all-ones, zero results.
    localparam logic [7:0] VEC [0:7] = '{8'h71, 8'h81, 8'h35, 8'hFF,
                                         8'h96, 8'hA5, 8'h44, 8'h00};

    always #2.5 clk = ~clk;

    nyb_alu_bank uut (
        .clk(clk), .rst_n(rst_n), .ab_wr_en(ab_wr_en), .ab_sel(ab_sel),
        .ab_wr_data(ab_wr_data), .cy_wr_en(cy_wr_en), .cy_wr_addr(cy_wr_addr),
        .cy_wr_data(cy_wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_stat(rd_stat)
    );

    // Reference result from the requirement text: returns {stat, data}.
    function automatic logic [7:0] ref_op(int op, logic [3:0] a, logic [3:0] b, logic ci);
        int ia = int'(a), ib = int'(b), ic = int'(ci);
        int sa = a[3] ? ia - 16 : ia;
        int sb = b[3] ? ib - 16 : ib;
        int s = 0, sv = 0;
        logic c = 1'b0, o = 1'b0;
        logic [3:0] r = '0;
        case (op)
            0, 1: begin
                s = ia + ib + ((op == 1) ? ic : 0);
                sv = sa + sb + ((op == 1) ? ic : 0);
                r = 4'(s % 16); c = (s > 15); o = (sv > 7) || (sv < -8);
            end
            2, 3, 8: begin
                s = ia - ib - ((op == 3) ? ic : 0);
                sv = sa - sb - ((op == 3) ? ic : 0);
                r = 4'((s + 32) % 16); c = (s < 0); o = (sv > 7) || (sv < -8);
            end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: r = 4'(15 - ia);
            9:  begin r = 4'((ia * 2) % 16);           c = a[3]; end
            10: begin r = 4'(ia / 2);                  c = a[0]; end
            11: begin r = 4'(ia / 2 + (a[3] ? 8 : 0)); c = a[0]; end
            12: begin r = 4'((ia * 2) % 16 + (a[3] ? 1 : 0)); c = a[3]; end
            13: begin r = 4'(ia / 2 + (a[0] ? 8 : 0)); c = a[0]; end
            14: begin r = 4'((ia * 2) % 16 + ic);      c = a[3]; end
            default: begin r = 4'(ia / 2 + ic * 8);    c = a[0]; end
        endcase
        return {o, r[3], (r == 4'd0), c, r};
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0:              return "R3";
            1, 3, 14, 15:   return "R5";
            2, 8:           return "R4";
            4, 5, 6, 7:     return "R6";
            default:        return "R7";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model_eval();
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = ref_op(i, ma, mb, mstat[i][0]);
            mdata[i] = v[3:0];
            mstat[i] = v[7:4];
        end
    endtask

    // Compare every unit through the read port; data and status (R8, R11).
    task automatic compare_all(string tag);
        for (int i = 0; i < 16; i++) begin
            rd_addr = 4'(i);
            #1;
            chk((tag == "") ? op_tag(i) : tag, $sformatf("unit %0d data", i), rd_data, mdata[i]);
            chk((tag == "") ? "R8" : tag, $sformatf("unit %0d stat", i), rd_stat, mstat[i]);
        end
    endtask

    task automatic wr_ab(logic sel, logic [3:0] v);
        @(negedge clk); ab_wr_en = 1'b1; ab_sel = sel; ab_wr_data = v;
        @(negedge clk); ab_wr_en = 1'b0;
        @(negedge clk);
        if (sel) mb = v; else ma = v;
        model_eval();
    endtask

    task automatic load_cy(logic [3:0] addr, logic [3:0] v);
        @(negedge clk); cy_wr_en = 1'b1; cy_wr_addr = addr; cy_wr_data = v;
        @(negedge clk); cy_wr_en = 1'b0;
        mstat[addr][0] = v[0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        ma = '0; mb = '0;
        for (int i = 0; i < 16; i++) begin mdata[i] = '0; mstat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every unit.
        compare_all("R1");

        // Seed carries so the chained units see Cin = 1 (R5, R9).
        load_cy(4'd1, 4'b0101);
        load_cy(4'd14, 4'b0011);
        compare_all("R9");

        // Vector table: A then B written, all units compared.
        for (int k = 0; k < 8; k++) begin
            wr_ab(1'b0, VEC[k][7:4]);
            compare_all("");
            wr_ab(1'b1, VEC[k][3:0]);
            compare_all("");
        end

        // R11: address map spot checks with A=3, B=5.
        wr_ab(1'b0, 4'd3);
        wr_ab(1'b1, 4'd5);
        rd_addr = 4'd5; #1; chk("R11", "OR unit", rd_data, 4'd7);
        rd_addr = 4'd4; #1; chk("R11", "AND unit", rd_data, 4'd1);
        rd_addr = 4'd0; #1; chk("R11", "ADD unit", rd_data, 4'd8);

        // R2: nothing changes on the edge that stores the operand.
        @(negedge clk); ab_wr_en = 1'b1; ab_sel = 1'b0; ab_wr_data = 4'd6;
        @(negedge clk); ab_wr_en = 1'b0;
        rd_addr = 4'd7; #1; chk("R2", "NOT before capture", rd_data, 4'd12);
        @(negedge clk);
        rd_addr = 4'd7; #1; chk("R2", "NOT after capture", rd_data, 4'd9);
        ma = 4'd6; model_eval();
        compare_all("R2");

        // R9: carry load plus capture on one edge; the loaded 0 wins.
        @(negedge clk); ab_wr_en = 1'b1; ab_sel = 1'b0; ab_wr_data = 4'd8;
        @(negedge clk); ab_wr_en = 1'b0;
        cy_wr_en = 1'b1; cy_wr_addr = 4'd14; cy_wr_data = 4'b1110;
        @(negedge clk); cy_wr_en = 1'b0;
        ma = 4'd8; model_eval(); mstat[14][0] = 1'b0;
        rd_addr = 4'd14; #1; chk("R9", "ROLC C after priority load", rd_stat[0], 4'd0);
        compare_all("R9");

        // R9: load only touches the addressed unit; bit 0 only.
        load_cy(4'd3, 4'b1111);
        compare_all("R9");

        // R10: repeated reads and idle cycles leave all state intact.
        compare_all("R10");
        repeat (10) @(negedge clk);
        compare_all("R10");

        // R1: reset after activity clears everything again.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        ma = '0; mb = '0;
        for (int i = 0; i < 16; i++) begin mdata[i] = '0; mstat[i] = '0; end
        compare_all("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule